// File: doc/BRIEF.md
# Serial Bus Master Burst Sequencer

This block runs a multi-byte burst on the master side of a two-wire serial bus. A burst command loads the programmed byte length into a down-counter that software can read. The block then asks the bit-level engine for a START and the address byte. After that it moves one data byte per engine completion event. In a transmit burst each byte comes from the transmit FIFO. In a receive burst each byte goes to the receive FIFO. The counter falls by one for every byte that is acknowledged.

Acknowledge failures are handled in three ways:
- A failure on the address byte always ends with a STOP.
- A failure on a data byte ends with a STOP when stop-enable was set at the command.
- Otherwise the block raises the NACK interrupt and holds the bus until software asks for a repeated START or a STOP.

In every failure case the counter keeps its value, so the number of bytes already moved is the programmed length minus the remaining count.

Both FIFO sides use valid/ready.
- Transmit side: a byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is raised only while the sequencer is waiting for the next transmit byte. The burst stalls for as long as the FIFO holds `tx_valid` low.
- Receive side: `rx_valid` goes high once the engine has received a byte. It stays high until `rx_ready` accepts the byte, and no further byte is requested in the meantime.

Top module: `burst_seq`

## Requirements
- R1: After reset the block is idle (`bus_idle`=1, `remaining`=0). When `cmd_go` and `cmd_burst_en` are high while idle and `cmd_len` is non-zero, the next cycle shows `remaining`=`cmd_len`, `bus_start`=1 for one cycle and `bus_idle`=0.
- R2: A burst command with `cmd_len`=0 starts no transfer: no `bus_start`, the block stays idle and `remaining` reads 0.
- R3: In a transmit burst, exactly one byte is taken from the transmit FIFO per data byte sent. `byte_go` never follows a cycle in which `tx_ready` was high and `tx_valid` low.
- R4: In a receive burst, exactly one byte is pushed per acknowledged received byte. Once `rx_valid` is raised it stays high until `rx_ready` is seen.
- R5: While busy, `remaining` either keeps its value or falls by exactly one, and it falls once per acknowledged byte.
- R6: When the last byte is acknowledged, `remaining` is 0, `burst_done` pulses, `bus_stop` pulses only if stop-enable was set at the command, and the block goes idle.
- R7: A data NACK with stop-enable set pulses `bus_stop` and `nack_irq` in the next cycle, the block goes idle, and `remaining` keeps its value. A transmit NACKed byte has already been taken from the FIFO.
- R8: A data NACK with stop-enable clear pulses `nack_irq` and raises `bus_hold` without a STOP. In hold, `cmd_halt` pulses `bus_stop` and the block goes idle. `cmd_restart` pulses `bus_start` and resumes the burst for the remaining bytes.
- R9: A NACK on the address byte always pulses `bus_stop` and `nack_irq`, whatever stop-enable holds, and keeps `remaining`.
- R10: `cmd_go` is ignored while a burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | Burst command strobe |
| cmd_burst_en | input | 1 | Qualifies `cmd_go` as a burst command |
| cmd_rx | input | 1 | 1 = receive burst, 0 = transmit burst; sampled at the command |
| cmd_stop_en | input | 1 | Issue STOP on completion or on data NACK; sampled at the command |
| cmd_len | input | LEN_W | Programmed burst length in bytes |
| cmd_restart | input | 1 | Repeated START request while holding |
| cmd_halt | input | 1 | STOP request while holding |
| eng_done | input | 1 | Engine finished the current address or data byte |
| eng_nack | input | 1 | Qualifies `eng_done`: the byte was not acknowledged |
| byte_go | output | 1 | One-cycle request to the engine for the next data byte |
| bus_start | output | 1 | One-cycle START (or repeated START) request with address |
| bus_stop | output | 1 | One-cycle STOP request |
| bus_idle | output | 1 | No burst in progress |
| bus_hold | output | 1 | Holding the bus after a data NACK |
| tx_valid | input | 1 | Transmit FIFO has a byte |
| tx_ready | output | 1 | Sequencer takes a transmit byte this cycle if valid |
| rx_valid | output | 1 | A received byte is waiting to be pushed |
| rx_ready | input | 1 | Receive FIFO can accept a byte |
| remaining | output | LEN_W | Bytes still to be acknowledged |
| burst_done | output | 1 | One-cycle pulse on normal completion |
| nack_irq | output | 1 | One-cycle pulse on any NACK |

## Verification
The hardest situation to reach is a data NACK on a chosen byte with stop-enable clear, followed by a repeated START that resumes the burst. The count must survive the hold, and the byte that was NACKed must be fetched again. The bench's engine model carries an armed NACK index that fires on one specific data byte and then disarms. After the hold, the bench drives the restart or the halt and predicts the totals of pops, pushes, starts and stops. Random FIFO valid/ready probabilities, down to heavy back-pressure, place stalls on both sides of every byte.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_XFER = 3'd3,
    ST_PUSH = 3'd4,
    ST_HOLD = 3'd5
  } seq_state_t;

  localparam int PULSE_N = 5;
  localparam int P_START = 0;
  localparam int P_STOP  = 1;
  localparam int P_DONE  = 2;
  localparam int P_NACK  = 3;
  localparam int P_BYTE  = 4;
endpackage

// File: rtl/burst_seq_count.sv
module burst_seq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (dec && count != '0)
      count <= count - ONE;
  end

  assign last = (count == ONE);
endmodule

// File: rtl/burst_seq_pulse.sv
module burst_seq_pulse #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i];
    end
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               burst_en,
  input  logic               rx_in,
  input  logic               stop_en_in,
  input  logic               len_zero,
  input  logic               restart,
  input  logic               halt,
  input  logic               eng_done,
  input  logic               eng_nack,
  input  logic               tx_valid,
  input  logic               rx_ready,
  input  logic               last,
  output logic               load,
  output logic               dec,
  output logic [PULSE_N-1:0] pset,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic               idle,
  output logic               hold
);
  seq_state_t st, nxt;
  logic rx_q, stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rx_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && go && burst_en && !len_zero) begin
        rx_q   <= rx_in;
        stop_q <= stop_en_in;
      end
    end
  end

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    dec      = 1'b0;
    pset     = '0;
    tx_ready = 1'b0;
    rx_valid = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (go && burst_en) begin
          load = 1'b1;
          if (!len_zero) begin
            pset[P_START] = 1'b1;
            nxt = ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        if (eng_done) begin
          if (eng_nack) begin
            pset[P_STOP] = 1'b1;
            pset[P_NACK] = 1'b1;
            nxt = ST_IDLE;
          end else begin
            nxt = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        tx_ready = !rx_q;
        if (rx_q || tx_valid) begin
          pset[P_BYTE] = 1'b1;
          nxt = ST_XFER;
        end
      end
      ST_XFER: begin
        if (eng_done) begin
          if (eng_nack) begin
            pset[P_NACK] = 1'b1;
            if (stop_q) begin
              pset[P_STOP] = 1'b1;
              nxt = ST_IDLE;
            end else begin
              nxt = ST_HOLD;
            end
          end else if (rx_q) begin
            nxt = ST_PUSH;
          end else begin
            dec = 1'b1;
            if (last) begin
              pset[P_DONE] = 1'b1;
              pset[P_STOP] = stop_q;
              nxt = ST_IDLE;
            end else begin
              nxt = ST_DATA;
            end
          end
        end
      end
      ST_PUSH: begin
        rx_valid = 1'b1;
        if (rx_ready) begin
          dec = 1'b1;
          if (last) begin
            pset[P_DONE] = 1'b1;
            pset[P_STOP] = stop_q;
            nxt = ST_IDLE;
          end else begin
            nxt = ST_DATA;
          end
        end
      end
      ST_HOLD: begin
        if (halt) begin
          pset[P_STOP] = 1'b1;
          nxt = ST_IDLE;
        end else if (restart) begin
          pset[P_START] = 1'b1;
          nxt = ST_ADDR;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign idle = (st == ST_IDLE);
  assign hold = (st == ST_HOLD);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_burst_en,
  input  logic             cmd_rx,
  input  logic             cmd_stop_en,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_restart,
  input  logic             cmd_halt,
  input  logic             eng_done,
  input  logic             eng_nack,
  output logic             byte_go,
  output logic             bus_start,
  output logic             bus_stop,
  output logic             bus_idle,
  output logic             bus_hold,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [LEN_W-1:0] remaining,
  output logic             burst_done,
  output logic             nack_irq
);
  logic               load, dec, last;
  logic [PULSE_N-1:0] pset, pq;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (cmd_go),
    .burst_en   (cmd_burst_en),
    .rx_in      (cmd_rx),
    .stop_en_in (cmd_stop_en),
    .len_zero   (cmd_len == '0),
    .restart    (cmd_restart),
    .halt       (cmd_halt),
    .eng_done   (eng_done),
    .eng_nack   (eng_nack),
    .tx_valid   (tx_valid),
    .rx_ready   (rx_ready),
    .last       (last),
    .load       (load),
    .dec        (dec),
    .pset       (pset),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .idle       (bus_idle),
    .hold       (bus_hold)
  );

  burst_seq_count #(.W(LEN_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cmd_len),
    .dec      (dec),
    .count    (remaining),
    .last     (last)
  );

  burst_seq_pulse #(.N(PULSE_N)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (pset),
    .q     (pq)
  );

  assign bus_start  = pq[P_START];
  assign bus_stop   = pq[P_STOP];
  assign burst_done = pq[P_DONE];
  assign nack_irq   = pq[P_NACK];
  assign byte_go    = pq[P_BYTE];
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_go,
  input logic             cmd_burst_en,
  input logic             cmd_stop_en,
  input logic [LEN_W-1:0] cmd_len,
  input logic             eng_done,
  input logic             eng_nack,
  input logic             byte_go,
  input logic             bus_start,
  input logic             bus_stop,
  input logic             bus_idle,
  input logic             bus_hold,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [LEN_W-1:0] remaining,
  input logic             burst_done,
  input logic             nack_irq
);
  logic addr_q, sten_q;
  logic in_addr;
  assign in_addr = bus_start || addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= 1'b0;
      sten_q <= 1'b0;
    end else begin
      addr_q <= in_addr && !eng_done;
      if (bus_idle && cmd_go && cmd_burst_en && cmd_len != '0)
        sten_q <= cmd_stop_en;
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && cmd_go && cmd_burst_en && cmd_len != '0) |=> (bus_start && !bus_idle && remaining == $past(cmd_len))); // R1
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && cmd_go && cmd_burst_en && cmd_len == '0) |=> (bus_idle && !bus_start && remaining == '0)); // R2
  AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !byte_go); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> (remaining == $past(remaining) || remaining == $past(remaining) - 1'b1)); // R5
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (remaining == '0 && bus_idle)); // R6
  AST_NACK_STOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_addr && !bus_idle && eng_done && eng_nack && sten_q) |=> (bus_stop && nack_irq && bus_idle)); // R7
  AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_addr && !bus_idle && eng_done && eng_nack && !sten_q) |=> (bus_hold && nack_irq && !bus_stop)); // R8
  AST_NACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && eng_done && eng_nack) |=> (remaining == $past(remaining))); // R7
  AST_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr && eng_done && eng_nack) |=> (bus_stop && nack_irq && bus_idle)); // R9
  AST_BUSY_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle && cmd_go) |=> !bus_start || $past(bus_hold)); // R10
endmodule

bind burst_seq burst_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_go       (cmd_go),
  .cmd_burst_en (cmd_burst_en),
  .cmd_stop_en  (cmd_stop_en),
  .cmd_len      (cmd_len),
  .eng_done     (eng_done),
  .eng_nack     (eng_nack),
  .byte_go      (byte_go),
  .bus_start    (bus_start),
  .bus_stop     (bus_stop),
  .bus_idle     (bus_idle),
  .bus_hold     (bus_hold),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .rx_valid     (rx_valid),
  .rx_ready     (rx_ready),
  .remaining    (remaining),
  .burst_done   (burst_done),
  .nack_irq     (nack_irq)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_go = 0, cmd_burst_en = 0, cmd_rx = 0, cmd_stop_en = 0;
  logic [7:0] cmd_len = 0;
  logic       cmd_restart = 0, cmd_halt = 0;
  logic       eng_done = 0, eng_nack = 0;
  logic       tx_valid = 0, rx_ready = 0;
  logic       byte_go, bus_start, bus_stop, bus_idle, bus_hold;
  logic       tx_ready, rx_valid, burst_done, nack_irq;
  logic [7:0] remaining;

  always #2 clk = ~clk;

  burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_burst_en(cmd_burst_en),
    .cmd_rx(cmd_rx), .cmd_stop_en(cmd_stop_en), .cmd_len(cmd_len),
    .cmd_restart(cmd_restart), .cmd_halt(cmd_halt), .eng_done(eng_done),
    .eng_nack(eng_nack), .byte_go(byte_go), .bus_start(bus_start),
    .bus_stop(bus_stop), .bus_idle(bus_idle), .bus_hold(bus_hold),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .remaining(remaining), .burst_done(burst_done),
    .nack_irq(nack_irq)
  );

  int total = 0, bad = 0;
  int txp = 100, rxp = 100;
  int n_start = 0, n_stop = 0, n_done = 0, n_nack = 0, n_pop = 0, n_push = 0;
  int byte_idx = 0, nack_idx_arm = -1;
  bit nack_addr_arm = 0;
  int pend_cnt = 0;
  bit pend_addr = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // engine model and FIFO model, all driven at the falling edge
  always @(negedge clk) begin
    eng_done = 1'b0;
    eng_nack = 1'b0;
    if (!rst_n) begin
      pend_cnt = 0;
    end else begin
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          eng_done = 1'b1;
          if (pend_addr) begin
            eng_nack = nack_addr_arm;
            nack_addr_arm = 0;
          end else begin
            eng_nack = (byte_idx == nack_idx_arm);
            if (eng_nack) nack_idx_arm = -1;
            byte_idx++;
          end
        end
      end
      if (bus_start) begin pend_cnt = 1 + int'($urandom % 3); pend_addr = 1; end
      if (byte_go)   begin pend_cnt = 1 + int'($urandom % 3); pend_addr = 0; end
    end
    tx_valid = (int'($urandom % 100) < txp);
    rx_ready = (int'($urandom % 100) < rxp);
    if (rst_n) begin
      if (tx_valid && tx_ready) n_pop++;
      if (rx_valid && rx_ready) n_push++;
      if (bus_start)  n_start++;
      if (bus_stop)   n_stop++;
      if (burst_done) n_done++;
      if (nack_irq)   n_nack++;
    end
  end

  function automatic int exp_rem(int len, bit na, int nk);
    if (na) return len;
    if (nk >= 0 && nk < len) return len - nk;
    return 0;
  endfunction

  task automatic wait_settle(input string req);
    int guard = 0;
    while (!(bus_idle || bus_hold) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, "burst finished in time", int'(guard < 4000), 1);
    @(negedge clk);
  endtask

  task automatic run_burst(input int len, input bit rx, input bit sten, input bit na,
                           input int nk, input bit use_restart, input bit busy_go);
    bit data_nack;
    int er;
    data_nack = !na && nk >= 0 && nk < len;
    er = exp_rem(len, na, nk);
    @(negedge clk);
    n_start = 0; n_stop = 0; n_done = 0; n_nack = 0; n_pop = 0; n_push = 0;
    byte_idx = 0; nack_addr_arm = na; nack_idx_arm = nk;
    cmd_len = 8'(len); cmd_rx = rx; cmd_stop_en = sten; cmd_burst_en = 1; cmd_go = 1;
    @(negedge clk);
    cmd_go = 0;
    if (len == 0) begin
      chk("R2", "remaining after zero-length go", int'(remaining), 0);
      chk("R2", "idle after zero-length go", int'(bus_idle), 1);
      repeat (4) @(negedge clk);
      chk("R2", "starts for zero length", n_start, 0);
      return;
    end
    chk("R1", "remaining loaded", int'(remaining), len);
    chk("R1", "start pulse", int'(bus_start), 1);
    if (busy_go) begin
      cmd_len = 8'd200; cmd_go = 1;
      @(negedge clk);
      cmd_go = 0;
    end
    wait_settle("R6");
    if (na) begin
      chk("R9", "stop after address nack", n_stop, 1);
      chk("R9", "nack irq after address nack", n_nack, 1);
      chk("R9", "remaining kept", int'(remaining), len);
      chk("R9", "idle", int'(bus_idle), 1);
      return;
    end
    if (data_nack) begin
      chk(sten ? "R7" : "R8", "nack irq", n_nack, 1);
      chk(sten ? "R7" : "R8", "remaining kept", int'(remaining), er);
      if (rx) chk("R4", "pushes before nack", n_push, nk);
      else    chk("R3", "pops incl nacked byte", n_pop, nk + 1);
      if (sten) begin
        chk("R7", "stop on data nack", n_stop, 1);
        chk("R7", "idle", int'(bus_idle), 1);
        return;
      end
      chk("R8", "holding", int'(bus_hold), 1);
      chk("R8", "no stop while holding", n_stop, 0);
      repeat (3) @(negedge clk);
      chk("R8", "still holding", int'(bus_hold), 1);
      if (!use_restart) begin
        cmd_halt = 1;
        @(negedge clk);
        cmd_halt = 0;
        @(negedge clk);
        chk("R8", "stop after halt", n_stop, 1);
        chk("R8", "idle after halt", int'(bus_idle), 1);
        return;
      end
      cmd_restart = 1;
      @(negedge clk);
      cmd_restart = 0;
      wait_settle("R8");
      chk("R8", "starts incl restart", n_start, 2);
      chk("R6", "done after resumed burst", n_done, 1);
      chk("R5", "remaining at end", int'(remaining), 0);
      if (rx) chk("R4", "pushes total", n_push, len);
      else    chk("R3", "pops total incl refetch", n_pop, len + 1);
      return;
    end
    chk("R6", "done pulses", n_done, 1);
    chk("R6", "stop pulses", n_stop, int'(sten));
    chk("R5", "remaining at end", int'(remaining), 0);
    chk("R6", "idle at end", int'(bus_idle), 1);
    chk(busy_go ? "R10" : "R1", "single start", n_start, 1);
    if (rx) chk("R4", "pushes", n_push, len);
    else    chk("R3", "pops", n_pop, len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog: actual=expired expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1", "reset idle", int'(bus_idle), 1);
    chk("R1", "reset remaining", int'(remaining), 0);
    chk("R1", "reset start", int'(bus_start), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run_burst(0, 0, 1, 0, -1, 0, 0);
    run_burst(1, 0, 1, 0, -1, 0, 0);
    run_burst(1, 1, 0, 0, -1, 0, 0);
    run_burst(255, 0, 1, 0, -1, 0, 0);
    run_burst(5, 0, 0, 1, -1, 0, 0);
    run_burst(5, 1, 1, 1, -1, 0, 0);
    run_burst(6, 0, 1, 0, 2, 0, 0);
    run_burst(6, 1, 1, 0, 0, 0, 0);
    run_burst(6, 0, 0, 0, 3, 0, 0);
    run_burst(6, 0, 0, 0, 5, 1, 0);
    run_burst(4, 1, 0, 0, 1, 1, 0);
    run_burst(7, 0, 1, 0, -1, 0, 1);
    txp = 15; rxp = 15;
    run_burst(8, 0, 1, 0, -1, 0, 0);
    run_burst(8, 1, 0, 0, -1, 0, 0);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      int len, nk, sel;
      txp = 10 + int'($urandom % 91);
      rxp = 10 + int'($urandom % 91);
      len = int'($urandom % 13);
      sel = int'($urandom % 4);
      nk = (sel == 0 && len > 0) ? int'($urandom % len) : -1;
      run_burst(len, 1'($urandom), 1'($urandom), (sel == 1), nk, 1'($urandom), (sel == 2));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule